// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block ranks a set of interrupt sources and offers the most urgent one to a processor core. Each source carries a request flag, an enable flag and a four-bit level. The block raises its request line only when the winning source outranks the level the core is already running at. The winning source's trap number and vector address are driven beside the request line. When the core acknowledges, the controller clears that source's flag and raises the running level to the winner's level. It keeps the level it left on an internal stack, and a return strobe restores that level later.

The lowest-numbered sources can also be set by eight fast external pins. Each pin has its own edge selector: off, rising, falling or both edges. Software writes a source's whole control word through a write port. Writing the request bit lets any source, including one with no hardware behind it, act as a software interrupt. A combinational read port shows any source's control word.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source reads as flag 0, enable 0, level 0; the running level is 0, `irqReq` is low and every edge selector is off.
- R2: A write with `regWrEn` high loads source `regWrIdx` on the next clock from `regWrData`, where bit 5 is the request flag, bit 4 the enable and bits 3:0 the level. `rdData` shows source `rdIdx` in the same layout, without delay.
- R3: `irqReq` is high exactly when some source with flag and enable both set has a level strictly above `cpuPrio`. A source at level 0 never raises it.
- R4: The winner is the flagged, enabled source with the highest level. Among equal levels, the lowest index wins.
- R5: While `irqReq` is high, `irqTrap` equals 0x18 plus the winner's index, and `irqVector` equals four times `irqTrap`.
- R6: `ack` while `irqReq` is high clears the winner's flag on the next clock. It also pushes the old `cpuPrio` and makes the winner's level the new `cpuPrio`.
- R7: A pending source whose level equals or is below `cpuPrio` is held back. It is offered as soon as `cpuPrio` drops below it.
- R8: `retInt` with `ack` low restores the most recently pushed level. With nothing pushed it has no effect, and it is ignored whenever `ack` is high.
- R9: `ack` while `irqReq` is low changes neither `cpuPrio` nor any flag.
- R10: Edge selector codes are 0 off, 1 rising, 2 falling, 3 both. The selector for pin e is written with `edgeWrEn`, `edgeIdx` and `edgeSel`. A matching change of `extIn[e]` seen at clock k sets the flag of source e at clock k+1, not at k.
- R11: An edge-set flag wins over a software write of 0 and over an acknowledge clear in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrIdx | input | 5 | Source written |
| regWrData | input | 6 | {flag, enable, level[3:0]} |
| rdIdx | input | 5 | Source shown on rdData |
| rdData | output | 6 | {flag, enable, level[3:0]} of rdIdx |
| edgeWrEn | input | 1 | Edge selector write strobe |
| edgeIdx | input | 3 | External pin whose selector is written |
| edgeSel | input | 2 | Selector code |
| extIn | input | 8 | Fast external pins, pin e feeds source e |
| ack | input | 1 | Core accepts the offered request |
| retInt | input | 1 | Core leaves the current service |
| irqReq | output | 1 | Request offered to the core |
| irqTrap | output | 8 | Trap number of the winner |
| irqVector | output | 10 | Vector address of the winner |
| cpuPrio | output | 4 | Running level |

## Verification
The bench targets equal-level ties, where a design with a reversed scan would offer the higher index. It also covers a request at exactly the running level, which an off-by-one compare would let preempt. A return with an empty stack would wrap the stack pointer and load a stale level. An acknowledge with no request would push a level, and a wrong edge pipeline would set a flag one clock early or late. The bench also checks an edge that lands in the same clock as a clearing write, where the wrong precedence loses the request.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int IDX_MAX_W = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic                 clrValid;
    logic [IDX_MAX_W-1:0] clrIdx;
  } ctrl_strobe_t;
endpackage

// File: rtl/intc_flags.sv
module intc_flags
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_EXT = 8,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int EXT_W  = $clog2(NUM_EXT)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic                      wrReq,
  input  logic                      wrEnable,
  input  logic [PRIO_W-1:0]         wrPrio,
  input  logic                      modeWrEn,
  input  logic [EXT_W-1:0]          modeIdx,
  input  edge_mode_e                modeVal,
  input  logic [NUM_EXT-1:0]        extIn,
  input  ctrl_strobe_t              strobe,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic [NUM_SRC-1:0]        enVec,
  output logic [NUM_SRC*PRIO_W-1:0] prioFlat
);
  logic [NUM_EXT-1:0] extPrev, edgeHit, edgeNow;
  logic [NUM_SRC-1:0] hitWide;
  edge_mode_e modeReg [NUM_EXT];

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_edge
    always_comb begin
      unique case (modeReg[e])
        EDGE_RISE: edgeNow[e] = ~extPrev[e] & extIn[e];
        EDGE_FALL: edgeNow[e] = extPrev[e] & ~extIn[e];
        EDGE_BOTH: edgeNow[e] = extPrev[e] ^ extIn[e];
        default:   edgeNow[e] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) modeReg[e] <= EDGE_OFF;
      else if (modeWrEn && int'(modeIdx) == e) modeReg[e] <= modeVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev <= '0;
      edgeHit <= '0;
    end else begin
      extPrev <= extIn;
      edgeHit <= edgeNow;
    end
  end

  assign hitWide = NUM_SRC'(edgeHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVec  <= '0;
      enVec    <= '0;
      prioFlat <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (wrEn && int'(wrIdx) == s) begin
          pendVec[s]                 <= wrReq;
          enVec[s]                   <= wrEnable;
          prioFlat[s*PRIO_W +: PRIO_W] <= wrPrio;
        end
        if (strobe.clrValid && int'(strobe.clrIdx) == s) pendVec[s] <= 1'b0;
        if (hitWide[s]) pendVec[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int PRIO_W    = 4,
  parameter int TRAP_BASE = 24,
  parameter int TRAP_W    = 8,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int VEC_W    = TRAP_W + 2,
  localparam int DEPTH    = (1 << PRIO_W) - 1,
  localparam int SP_W     = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendVec,
  input  logic [NUM_SRC-1:0]        enVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic                      ack,
  input  logic                      retInt,
  output logic                      irqReq,
  output logic [TRAP_W-1:0]         irqTrap,
  output logic [VEC_W-1:0]          irqVector,
  output logic [PRIO_W-1:0]         cpuPrio,
  output logic [IDX_W-1:0]          winIdx,
  output logic [PRIO_W-1:0]         winLvl,
  output ctrl_strobe_t              strobe
);
  localparam int VEC_BASE = TRAP_BASE * 4;

  logic [PRIO_W-1:0] stackMem [1 << SP_W];
  logic [SP_W-1:0]   sp, spDec;
  logic              ackTake, retTake;

  always_comb begin
    winLvl = '0;
    winIdx = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pendVec[s] && enVec[s] && prioFlat[s*PRIO_W +: PRIO_W] > winLvl) begin
        winLvl = prioFlat[s*PRIO_W +: PRIO_W];
        winIdx = IDX_W'(s);
      end
    end
  end

  assign irqReq    = winLvl > cpuPrio;
  assign irqTrap   = TRAP_W'(TRAP_BASE) + TRAP_W'(winIdx);
  assign irqVector = VEC_W'(VEC_BASE) + (VEC_W'(winIdx) << 2);

  assign ackTake = ack && irqReq;
  assign retTake = retInt && !ack && (sp != '0);
  assign spDec   = sp - SP_W'(1);

  assign strobe.clrValid = ackTake;
  assign strobe.clrIdx   = IDX_MAX_W'(winIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp      <= '0;
      cpuPrio <= '0;
      for (int d = 0; d < (1 << SP_W); d++) stackMem[d] <= '0;
    end else if (ackTake) begin
      stackMem[sp] <= cpuPrio;
      sp           <= sp + SP_W'(1);
      cpuPrio      <= winLvl;
    end else if (retTake) begin
      sp      <= spDec;
      cpuPrio <= stackMem[spDec];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_EXT   = 8,
  parameter int PRIO_W    = 4,
  parameter int TRAP_BASE = 24,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int EXT_W    = $clog2(NUM_EXT),
  localparam int WORD_W   = PRIO_W + 2,
  localparam int TRAP_W   = 8,
  localparam int VEC_W    = TRAP_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [IDX_W-1:0]   regWrIdx,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [WORD_W-1:0]  rdData,
  input  logic               edgeWrEn,
  input  logic [EXT_W-1:0]   edgeIdx,
  input  logic [1:0]         edgeSel,
  input  logic [NUM_EXT-1:0] extIn,
  input  logic               ack,
  input  logic               retInt,
  output logic               irqReq,
  output logic [TRAP_W-1:0]  irqTrap,
  output logic [VEC_W-1:0]   irqVector,
  output logic [PRIO_W-1:0]  cpuPrio
);
  logic [NUM_SRC-1:0]        pendVec, enVec;
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [IDX_W-1:0]          winIdx;
  logic [PRIO_W-1:0]         winLvl;
  ctrl_strobe_t              strobe;

  intc_flags #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) flags_i (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrIdx(regWrIdx),
    .wrReq(regWrData[PRIO_W+1]), .wrEnable(regWrData[PRIO_W]), .wrPrio(regWrData[PRIO_W-1:0]),
    .modeWrEn(edgeWrEn), .modeIdx(edgeIdx), .modeVal(edge_mode_e'(edgeSel)),
    .extIn(extIn), .strobe(strobe),
    .pendVec(pendVec), .enVec(enVec), .prioFlat(prioFlat)
  );

  intc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .TRAP_BASE(TRAP_BASE), .TRAP_W(TRAP_W)) arb_i (
    .clk(clk), .rstN(rstN),
    .pendVec(pendVec), .enVec(enVec), .prioFlat(prioFlat),
    .ack(ack), .retInt(retInt),
    .irqReq(irqReq), .irqTrap(irqTrap), .irqVector(irqVector), .cpuPrio(cpuPrio),
    .winIdx(winIdx), .winLvl(winLvl), .strobe(strobe)
  );

  assign rdData = {pendVec[rdIdx], enVec[rdIdx], prioFlat[int'(rdIdx)*PRIO_W +: PRIO_W]};
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 32,
  parameter int NUM_EXT = 8,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               ack,
  input logic               retInt,
  input logic               regWrEn,
  input logic [IDX_W-1:0]   regWrIdx,
  input logic               irqReq,
  input logic [7:0]         irqTrap,
  input logic [9:0]         irqVector,
  input logic [PRIO_W-1:0]  cpuPrio,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] enVec,
  input logic [IDX_W-1:0]   winIdx,
  input logic [PRIO_W-1:0]  winLvl
);
  assert_ack_loads_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    ack && irqReq |=> cpuPrio == $past(winLvl));

  assert_flag_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    ack && irqReq && int'(winIdx) >= NUM_EXT && !(regWrEn && regWrIdx == winIdx)
    |=> !pendVec[$past(winIdx)]);

  assert_vector_scale_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqVector == {irqTrap, 2'b00});

  assert_top_level_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuPrio == '1 |-> !irqReq);

  assert_winner_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> pendVec[winIdx] && enVec[winIdx]);

  assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    ack && !irqReq |=> $stable(cpuPrio));

  assert_level_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ack && !retInt |=> $stable(cpuPrio));
endmodule

bind prio_irq_ctrl intc_checker #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rstN(rstN), .ack(ack), .retInt(retInt),
  .regWrEn(regWrEn), .regWrIdx(regWrIdx),
  .irqReq(irqReq), .irqTrap(irqTrap), .irqVector(irqVector), .cpuPrio(cpuPrio),
  .pendVec(pendVec), .enVec(enVec), .winIdx(winIdx), .winLvl(winLvl)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [4:0] regWrIdx = '0;
  logic [5:0] regWrData = '0;
  logic [4:0] rdIdx = '0;
  logic [5:0] rdData;
  logic       edgeWrEn = 1'b0;
  logic [2:0] edgeIdx = '0;
  logic [1:0] edgeSel = '0;
  logic [7:0] extIn = '0;
  logic       ack = 1'b0;
  logic       retInt = 1'b0;
  logic       irqReq;
  logic [7:0] irqTrap;
  logic [9:0] irqVector;
  logic [3:0] cpuPrio;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // behavioural reference state
  int mFlag [32];
  int mEn   [32];
  int mPrio [32];
  int mMode [8];
  int mPrev [8];
  int mHit  [8];
  int mCpu;
  int mStk [$];

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .rdIdx(rdIdx), .rdData(rdData),
    .edgeWrEn(edgeWrEn), .edgeIdx(edgeIdx), .edgeSel(edgeSel),
    .extIn(extIn), .ack(ack), .retInt(retInt),
    .irqReq(irqReq), .irqTrap(irqTrap), .irqVector(irqVector), .cpuPrio(cpuPrio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void modelBest(output int lvl, output int idx);
    lvl = 0; idx = 0;
    for (int s = 0; s < 32; s++)
      if (mFlag[s] != 0 && mEn[s] != 0 && mPrio[s] > lvl) begin
        lvl = mPrio[s]; idx = s;
      end
  endfunction

  // reference update at each clock
  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 32; s++) begin mFlag[s] = 0; mEn[s] = 0; mPrio[s] = 0; end
      for (int e = 0; e < 8; e++) begin mMode[e] = 0; mPrev[e] = 0; mHit[e] = 0; end
      mCpu = 0;
      mStk.delete();
    end else begin
      int bl, bi, nh [8];
      bit take;
      modelBest(bl, bi);
      take = ack && (bl > mCpu);
      for (int s = 0; s < 32; s++) begin
        if (regWrEn && int'(regWrIdx) == s) begin
          mFlag[s] = regWrData[5]; mEn[s] = regWrData[4]; mPrio[s] = int'(regWrData[3:0]);
        end
        if (take && s == bi) mFlag[s] = 0;
        if (s < 8 && mHit[s] != 0) mFlag[s] = 1;
      end
      for (int e = 0; e < 8; e++) begin
        case (mMode[e])
          1: nh[e] = (mPrev[e] == 0 && extIn[e]) ? 1 : 0;
          2: nh[e] = (mPrev[e] == 1 && !extIn[e]) ? 1 : 0;
          3: nh[e] = (mPrev[e] != int'(extIn[e])) ? 1 : 0;
          default: nh[e] = 0;
        endcase
      end
      for (int e = 0; e < 8; e++) begin
        mHit[e] = nh[e];
        mPrev[e] = int'(extIn[e]);
        if (edgeWrEn && int'(edgeIdx) == e) mMode[e] = int'(edgeSel);
      end
      if (take) begin
        mStk.push_back(mCpu); mCpu = bl;
      end else if (retInt && !ack && mStk.size() > 0) begin
        mCpu = mStk.pop_back();
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int bl, bi, ew;
      modelBest(bl, bi);
      chk(irqReq == (bl > mCpu), "R3 irqReq", int'(irqReq), int'(bl > mCpu));
      chk(int'(cpuPrio) == mCpu, "R6 cpuPrio", int'(cpuPrio), mCpu);
      if (bl > mCpu) begin
        chk(int'(irqTrap) == 24 + bi, "R4 R5 trap", int'(irqTrap), 24 + bi);
        chk(int'(irqVector) == 4 * (24 + bi), "R5 vector", int'(irqVector), 4 * (24 + bi));
      end
      ew = mFlag[rdIdx] * 32 + mEn[rdIdx] * 16 + mPrio[rdIdx];
      chk(int'(rdData) == ew, "R2 rdData", int'(rdData), ew);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int idx, input bit req, input bit en, input int lvl);
    regWrEn = 1'b1; regWrIdx = 5'(idx); regWrData = {req, en, 4'(lvl)};
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic setMode(input int e, input int code);
    edgeWrEn = 1'b1; edgeIdx = 3'(e); edgeSel = 2'(code);
    tick();
    edgeWrEn = 1'b0;
  endtask

  task automatic pulse(input bit a, input bit r);
    ack = a; retInt = r;
    tick();
    ack = 1'b0; retInt = 1'b0;
  endtask

  task automatic readFlag(input int idx, input int exp, input string req);
    rdIdx = 5'(idx); #0.5;
    chk(int'(rdData[5]) == exp, req, int'(rdData[5]), exp);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: reset state
    for (int s = 0; s < 32; s++) begin
      rdIdx = 5'(s); #0.1;
      chk(rdData == 6'd0, "R1 word", int'(rdData), 0);
    end
    chk(!irqReq && cpuPrio == 0, "R1 outputs", int'({irqReq, cpuPrio}), 0);

    // R2/R5: single software request
    wr(5, 1, 1, 3);
    rdIdx = 5; #0.1;
    chk(rdData == 6'h33, "R2 readback", int'(rdData), 'h33);
    chk(irqReq && irqTrap == 8'h1D && irqVector == 10'h74, "R5 src5", int'(irqVector), 'h74);
    // R4 tie: lower index wins
    wr(9, 1, 1, 3);
    chk(irqTrap == 8'h1D, "R4 tie", int'(irqTrap), 'h1D);
    // R6 acknowledge
    pulse(1, 0);
    chk(cpuPrio == 3, "R6 level", int'(cpuPrio), 3);
    readFlag(5, 0, "R6 clear");
    // R7 equal level held back
    chk(!irqReq, "R7 equal held", int'(irqReq), 0);
    wr(20, 1, 1, 7);
    chk(irqReq && irqTrap == 8'h2C, "R7 preempt", int'(irqTrap), 'h2C);
    pulse(1, 0);
    chk(cpuPrio == 7, "R6 nested", int'(cpuPrio), 7);
    // R9 idle ack
    pulse(1, 0);
    chk(cpuPrio == 7, "R9 idle ack", int'(cpuPrio), 7);
    readFlag(9, 1, "R9 flag kept");
    // R8 ack with ret: ret ignored
    pulse(1, 1);
    chk(cpuPrio == 7, "R8 ret with ack", int'(cpuPrio), 7);
    pulse(0, 1);
    chk(cpuPrio == 3, "R8 pop", int'(cpuPrio), 3);
    pulse(0, 1);
    chk(cpuPrio == 0 && irqReq, "R7 released", int'(cpuPrio), 0);
    pulse(0, 1);
    chk(cpuPrio == 0, "R8 empty pop", int'(cpuPrio), 0);
    // R3 level 0 never requests
    wr(9, 1, 1, 0);
    chk(!irqReq, "R3 level zero", int'(irqReq), 0);

    // R10 edge modes
    setMode(0, 1); setMode(1, 2); setMode(2, 3); setMode(3, 0);
    extIn = 8'b0000_0010;
    tick(); tick();
    wr(1, 0, 0, 0);
    extIn = 8'b0000_1111;          // rise on 0,2,3
    tick();
    readFlag(0, 0, "R10 not early");
    tick();
    readFlag(0, 1, "R10 rising");
    readFlag(2, 1, "R10 both rise");
    readFlag(3, 0, "R10 off");
    readFlag(1, 0, "R10 falling ignores rise");
    wr(2, 0, 0, 0);
    extIn = 8'b0000_1000;          // fall on 0,1,2
    tick(); tick();
    readFlag(1, 1, "R10 falling");
    readFlag(2, 1, "R10 both fall");
    // R11 edge beats clearing write
    wr(0, 0, 0, 0);
    extIn = 8'b0000_1001;
    tick();
    wr(0, 0, 1, 2);
    readFlag(0, 1, "R11 edge wins");

    // mixed stress, reference compared every clock
    for (int n = 0; n < 600; n++) begin
      regWrEn  = ($urandom_range(0, 3) == 0);
      regWrIdx = 5'($urandom_range(0, 31));
      regWrData = 6'($urandom_range(0, 63));
      edgeWrEn = ($urandom_range(0, 7) == 0);
      edgeIdx  = 3'($urandom_range(0, 7));
      edgeSel  = 2'($urandom_range(0, 3));
      extIn    = 8'($urandom_range(0, 255));
      ack      = ($urandom_range(0, 2) == 0);
      retInt   = ($urandom_range(0, 3) == 0);
      rdIdx    = 5'($urandom_range(0, 31));
      tick();
    end
    regWrEn = 1'b0; edgeWrEn = 1'b0; ack = 1'b0; retInt = 1'b0;
    tick();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule